// File: doc/BRIEF.md
# Supply-Loss Write Guard Sequencer

This synchronous controller sits between a set of external supply comparators and a battery-backed static memory. Each comparator reports one of four supply thresholds as a level. From those levels the block decides three things. It decides whether the memory may be accessed at all. It decides whether writes are blocked and the data outputs are held high-impedance. It decides whether storage power comes from the main supply or from the backup cell. Each comparator level first passes through a two-flop synchronizer and then a stability filter. The sequencer then walks four named states.

- `PS_BACKUP`: supply below the switchover level.
- `PS_GUARD`: main supply present, memory protected.
- `PS_HOLDOFF`: supply at full-function level, recovery window being counted.
- `PS_ACTIVE`: accesses allowed.

The transitions are:

- T1: `PS_BACKUP`→`PS_GUARD` when the switchover level is regained.
- T2: `PS_GUARD`→`PS_HOLDOFF` when the full-function level is seen.
- T3: `PS_HOLDOFF`→`PS_GUARD` when the full-function or trip level is lost.
- T4: `PS_HOLDOFF`→`PS_ACTIVE` when the recovery count expires.
- T5: `PS_ACTIVE`→`PS_GUARD` when the trip level is lost.
- T6: any state→`PS_BACKUP` when the switchover level is lost. T6 has priority over all the others.

A new part ships with its backup cell disconnected. An arm bit is set the first time the filtered seal comparator is high. Only then may the cell be switched in. The arm bit keeps its value through the ordinary reset. Only the dedicated seal-clear input clears it. Writes become blocked at the trip level. Access only returns once the higher full-function level is reached. The gap between those two levels is the hysteresis.

Top module: `pfw_seq`

## Requirements
- R1: While `rst_n` is low and after its release with all comparator inputs low, `acc_en`=0, `wr_prot`=1, `dout_hiz`=1 and `bat_sel`=0; with `seal_rst`=1 held during reset, `bat_armed`=0.
- R2: Each comparator input passes two synchronizer flops and takes effect only after its synchronized value has differed from the filtered value for FILT_LEN consecutive clocks. A raw pulse shorter than FILT_LEN clocks changes no output.
- R3: Once the filtered trip level is low, `acc_en` is 0 from the next clock, with `wr_prot`=1 and `dout_hiz`=1.
- R4: Once in `PS_GUARD`, the supply regaining only the trip level (full-function level still low) does not re-enable access.
- R5: Access is enabled exactly REC_CYC = (CLK_HZ/1e6)·HOLDOFF_US clocks after entering `PS_HOLDOFF`. A raw rise of all four inputs, from the backup state, gives `acc_en`=1 at clock 4+FILT_LEN+REC_CYC and not before. Losing the full-function level during the window restarts it.
- R6: In `PS_BACKUP`, `bat_sel` is 1 when armed. It returns to 0 one clock after the filtered switchover level is high again.
- R7: While unarmed, `bat_sel` stays 0 in every state, including below the switchover level.
- R8: `bat_armed` becomes 1 on the clock after the filtered seal level is high. It holds through `rst_n` pulses and returns to 0 only on a clock with `seal_rst`=1.
- R9: `wr_prot` and `dout_hiz` are both 1 in every state except `PS_ACTIVE`, where both are 0 and `acc_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; does not touch the arm bit |
| seal_rst | input | 1 | Synchronous factory clear of the arm bit |
| cmp_swo | input | 1 | Supply above switchover level |
| cmp_trip | input | 1 | Supply above write-protect trip level |
| cmp_full | input | 1 | Supply above full-function level |
| cmp_seal | input | 1 | Supply above seal-arming level |
| acc_en | output | 1 | Memory accesses allowed |
| wr_prot | output | 1 | Writes blocked |
| dout_hiz | output | 1 | Memory data outputs forced high-impedance |
| bat_sel | output | 1 | Storage powered from backup cell |
| bat_armed | output | 1 | Backup cell armed (seal broken) |

## Verification
The bench builds the block with FILT_LEN=3, CLK_HZ=1_000_000 and HOLDOFF_US=12, so the recovery window is 12 clocks instead of hundreds of thousands. With these values, hundreds of full power cycles fit in one run. These include aborted hold-off windows, glitches just under the filter length and hysteresis round trips. The short filter also makes the exact 19-clock power-up latency a directed check.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
    typedef enum logic [1:0] {
        PS_BACKUP  = 2'd0,
        PS_GUARD   = 2'd1,
        PS_HOLDOFF = 2'd2,
        PS_ACTIVE  = 2'd3
    } pfw_state_e;

    localparam int NFLAG  = 4;
    localparam int FL_SWO  = 0;
    localparam int FL_TRIP = 1;
    localparam int FL_FULL = 2;
    localparam int FL_SEAL = 3;
endpackage

// File: rtl/pfw_flag_filter.sv
module pfw_flag_filter #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic          s1, s2;
    logic [FW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            filt <= 1'b0;
            cnt  <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 == filt) begin
                cnt <= '0;
            end else if (cnt == FW'(FILT_LEN - 1)) begin
                filt <= s2;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> (filt == $past(s2))); // R2
endmodule

// File: rtl/pfw_holdoff.sv
module pfw_holdoff #(
    parameter int REC_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(REC_CYC + 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == CW'(REC_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (!done)  cnt <= cnt + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(REC_CYC - 1)); // R5
endmodule

// File: rtl/pfw_seal.sv
module pfw_seal (
    input  logic clk,
    input  logic rst_n,
    input  logic seal_rst,
    input  logic seal_lvl,
    output logic armed
);
    // No rst_n term: the arm bit must survive ordinary resets.
    always_ff @(posedge clk) begin
        if (seal_rst)      armed <= 1'b0;
        else if (seal_lvl) armed <= 1'b1;
    end

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed) |-> $past(seal_rst)); // R8
endmodule

// File: rtl/pfw_seq.sv
module pfw_seq
    import pfw_pkg::*;
#(
    parameter int FILT_LEN   = 8,
    parameter int CLK_HZ     = 50_000_000,
    parameter int HOLDOFF_US = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seal_rst,
    input  logic cmp_swo,
    input  logic cmp_trip,
    input  logic cmp_full,
    input  logic cmp_seal,
    output logic acc_en,
    output logic wr_prot,
    output logic dout_hiz,
    output logic bat_sel,
    output logic bat_armed
);
    localparam int REC_CYC = (CLK_HZ / 1_000_000) * HOLDOFF_US;

    logic [NFLAG-1:0] raw_v, lvl_v;
    pfw_state_e       st, st_nx;
    logic             hold_done;

    assign raw_v = {cmp_seal, cmp_full, cmp_trip, cmp_swo};

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flt
        pfw_flag_filter #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_v[gi]),
            .filt (lvl_v[gi])
        );
    end

    pfw_holdoff #(.REC_CYC(REC_CYC)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st == PS_HOLDOFF),
        .done (hold_done)
    );

    pfw_seal u_seal (
        .clk     (clk),
        .rst_n   (rst_n),
        .seal_rst(seal_rst),
        .seal_lvl(lvl_v[FL_SEAL]),
        .armed   (bat_armed)
    );

    always_comb begin
        st_nx = st;
        if (!lvl_v[FL_SWO]) begin
            st_nx = PS_BACKUP;
        end else begin
            unique case (st)
                PS_BACKUP:  st_nx = PS_GUARD;
                PS_GUARD:   if (lvl_v[FL_FULL]) st_nx = PS_HOLDOFF;
                PS_HOLDOFF: begin
                    if (!lvl_v[FL_FULL] || !lvl_v[FL_TRIP]) st_nx = PS_GUARD;
                    else if (hold_done)                      st_nx = PS_ACTIVE;
                end
                PS_ACTIVE:  if (!lvl_v[FL_TRIP]) st_nx = PS_GUARD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PS_BACKUP;
        else        st <= st_nx;
    end

    always_comb begin
        unique case (st)
            PS_ACTIVE: begin
                acc_en   = 1'b1;
                wr_prot  = 1'b0;
                dout_hiz = 1'b0;
                bat_sel  = 1'b0;
            end
            PS_BACKUP: begin
                acc_en   = 1'b0;
                wr_prot  = 1'b1;
                dout_hiz = 1'b1;
                bat_sel  = bat_armed;
            end
            default: begin
                acc_en   = 1'b0;
                wr_prot  = 1'b1;
                dout_hiz = 1'b1;
                bat_sel  = 1'b0;
            end
        endcase
    end

    AST_TRIP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_v[FL_TRIP] |=> !acc_en); // R3
    AST_ACC_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_en) |-> $past(lvl_v[FL_FULL])); // R5
    AST_BAT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        bat_sel |-> bat_armed); // R7
    AST_BAT_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bat_sel) |-> ($past(!lvl_v[FL_SWO]) || $past(st == PS_BACKUP))); // R6
endmodule

// File: tb/sim_pfw_seq.sv
module sim_pfw_seq;
    localparam int FILT = 3;
    localparam int REC  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic seal_rst = 1'b1;
    logic [3:0] raw = 4'b0;          // {seal, full, trip, swo}
    logic acc_en, wr_prot, dout_hiz, bat_sel, bat_armed;
    int n_chk = 0, n_bad = 0;
    bit tracking = 1'b0;

    always #5 clk = ~clk;

    pfw_seq #(.FILT_LEN(FILT), .CLK_HZ(1_000_000), .HOLDOFF_US(REC)) u0 (
        .clk(clk), .rst_n(rst_n), .seal_rst(seal_rst),
        .cmp_swo(raw[0]), .cmp_trip(raw[1]), .cmp_full(raw[2]), .cmp_seal(raw[3]),
        .acc_en(acc_en), .wr_prot(wr_prot), .dout_hiz(dout_hiz),
        .bat_sel(bat_sel), .bat_armed(bat_armed)
    );

    // Reference model built from the requirements.
    logic [3:0] m_s1, m_s2, m_f;
    int m_c [4];
    int m_st, m_hc;
    logic m_arm;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_f <= '0;
            for (int i = 0; i < 4; i++) m_c[i] <= 0;
            m_st <= 0; m_hc <= 0;
        end else begin
            m_s1 <= raw; m_s2 <= m_s1;
            for (int i = 0; i < 4; i++) begin
                if (m_s2[i] == m_f[i]) m_c[i] <= 0;
                else if (m_c[i] == FILT - 1) begin m_f[i] <= m_s2[i]; m_c[i] <= 0; end
                else m_c[i] <= m_c[i] + 1;
            end
            m_hc <= 0;
            if (!m_f[0]) m_st <= 0;
            else case (m_st)
                0: m_st <= 1;
                1: if (m_f[2]) m_st <= 2;
                2: if (!m_f[2] || !m_f[1]) m_st <= 1;
                   else if (m_hc == REC - 1) m_st <= 3;
                   else m_hc <= m_hc + 1;
                default: if (!m_f[1]) m_st <= 1;
            endcase
        end
    end

    always @(posedge clk) begin
        if (seal_rst) m_arm <= 1'b0;
        else if (m_f[3]) m_arm <= 1'b1;
    end

    function automatic logic [3:0] lvl2raw(input int l);
        return {l >= 2, l >= 4, l >= 3, l >= 1};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (tracking) begin
        chk(acc_en == (m_st == 3), "R5 acc_en vs model", acc_en, m_st == 3);
        chk(wr_prot == (m_st != 3), "R9 wr_prot vs model", wr_prot, m_st != 3);
        chk(dout_hiz == (m_st != 3), "R9 dout_hiz vs model", dout_hiz, m_st != 3);
        chk(bat_sel == (m_st == 0 && m_arm), "R6 bat_sel vs model", bat_sel, m_st == 0 && m_arm);
        chk(bat_armed == m_arm, "R8 bat_armed vs model", bat_armed, m_arm);
    end

    task automatic hold_lvl(input int l, input int n);
        raw = lvl2raw(l);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(acc_en == 0 && wr_prot == 1 && dout_hiz == 1 && bat_sel == 0, "R1 outputs in reset",
            {acc_en, wr_prot, dout_hiz, bat_sel}, 4'b0110);
        rst_n = 1'b1;
        @(negedge clk);
        seal_rst = 1'b0;
        chk(bat_armed == 0, "R1 armed cleared", bat_armed, 0);
        tracking = 1'b1;
        // R7: unarmed loss of supply keeps cell disconnected
        hold_lvl(1, 20);
        hold_lvl(0, 20);
        chk(bat_sel == 0, "R7 unarmed bat_sel", bat_sel, 0);
        // R5: exact power-up latency from backup state
        raw = 4'hF;
        repeat (4 + FILT + REC - 1) @(negedge clk);
        chk(acc_en == 0, "R5 not before window", acc_en, 0);
        @(negedge clk);
        chk(acc_en == 1, "R5 enabled at window end", acc_en, 1);
        chk(bat_armed == 1, "R8 armed by seal level", bat_armed, 1);
        // R2: short glitch ignored
        hold_lvl(2, FILT - 1);
        hold_lvl(4, 12);
        chk(acc_en == 1, "R2 glitch ignored", acc_en, 1);
        // R3 / R4: trip loss and hysteresis
        hold_lvl(3, 15);
        chk(acc_en == 1, "R4 above trip stays active", acc_en, 1);
        hold_lvl(2, 15);
        chk(acc_en == 0 && wr_prot == 1 && dout_hiz == 1, "R3 trip loss protects",
            {acc_en, wr_prot, dout_hiz}, 3'b011);
        hold_lvl(3, 30);
        chk(acc_en == 0, "R4 trip alone does not resume", acc_en, 0);
        hold_lvl(4, 30);
        chk(acc_en == 1, "R4 full level resumes", acc_en, 1);
        // R6 / R8: armed backup, survives rst_n
        hold_lvl(0, 15);
        chk(bat_sel == 1, "R6 armed backup selects cell", bat_sel, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bat_armed == 1, "R8 armed survives rst_n", bat_armed, 1);
        hold_lvl(1, 10);
        chk(bat_sel == 0, "R6 cell released on switchover", bat_sel, 0);
        hold_lvl(0, 10);
        seal_rst = 1'b1;
        @(negedge clk);
        seal_rst = 1'b0;
        chk(bat_armed == 0 && bat_sel == 0, "R8 seal clear disarms", {bat_armed, bat_sel}, 0);
        // Random level walk with glitches, checked against the model.
        void'($urandom(32'd1234));
        for (int k = 0; k < 2500; k++) begin
            int l, n;
            l = $urandom_range(0, 4);
            n = ($urandom_range(0, 3) == 0) ? $urandom_range(1, FILT) : $urandom_range(1, 30);
            if ($urandom_range(0, 200) == 0) seal_rst = 1'b1;
            hold_lvl(l, n);
            seal_rst = 1'b0;
        end
        tracking = 1'b0;
        finish_run();
    end
endmodule